// File: doc/BRIEF.md
# Twin-Predicated Indexed Address Sequencer

This block walks through the elements of a vectorised indexed load or store and emits one effective address per element. Each address is the sum of two register operands: a base element and an offset element. The block keeps three element counters, one for the base operand, one for the offset operand and one for the destination. Each counter moves on its own, depending on whether its operand is marked as a vector and on which predicate mask governs it. The base and offset counters both follow a shared source predicate. The destination counter follows its own destination predicate.

A start pulse captures the vector length, both masks, the three vector flags and the write-back enable while the block is idle. From then on the block presents the base and offset indices to an external register file. It adds the two values that come back and offers the element to the memory stage through a valid/ready handshake, at most one element per cycle. When the walk ends, a one-cycle done pulse follows. When write-back is enabled, each element also requests that its effective address be written back into the base register element it was read from.

Top module: `idx_addr_seq`

## Requirements
- R1: For every offered element, `out_ea` equals `base_data + offs_data` (modulo 2^AW), where the two data inputs are the register values at `out_base_idx` and `out_offs_idx`.
- R2: When the base (or offset) operand is marked vector, its offered index is the lowest position at or after its current count whose bit in `src_pred` (bit n = element n) is set. When the operand is scalar, its index is always 0.
- R3: When the destination is marked vector, `out_dst_idx` is the lowest position at or after its current count whose `dst_pred` bit is set. When the destination is scalar, the index is 0.
- R4: The walk ends without offering an element as soon as any of the three indices, after skipping, is not below the captured VL. A VL of 0 offers no element.
- R5: With a scalar destination, the walk ends after the first accepted element.
- R6: With both base and offset scalar, the walk ends after the first accepted element.
- R7: After an accepted element, each vector-marked counter moves to one past its offered index. Scalar counters stay at 0.
- R8: With write-back enabled, `out_wb` is high alongside every offered element. The write target is `out_base_idx` and the value is `out_ea`. With write-back disabled, `out_wb` stays low.
- R9: `start` is accepted only while `busy` is low. A start pulse during a walk changes neither the captured configuration nor the element sequence.
- R10: `done` is high for exactly one cycle, in the cycle after the final handshake or after the cycle that found an index out of range. `busy` is low while `done` is high.
- R11: While `out_valid` is high and `out_ready` is low, the element is held: valid stays high and the three indices stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture configuration and begin a walk (ignored while busy) |
| vl | input | IW | Vector length, 0 to VL_MAX |
| src_pred | input | VL_MAX | Source predicate shared by base and offset operands |
| dst_pred | input | VL_MAX | Destination predicate |
| base_vec | input | 1 | Base operand is a vector |
| offs_vec | input | 1 | Offset operand is a vector |
| dst_vec | input | 1 | Destination is a vector |
| upd_en | input | 1 | Request write-back of each address into the base element |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse after a walk ends |
| base_data | input | AW | Register value at `out_base_idx` |
| offs_data | input | AW | Register value at `out_offs_idx` |
| out_valid | output | 1 | Element offered to the memory stage |
| out_ready | input | 1 | Memory stage accepts the element |
| out_base_idx | output | IW | Base element index (also register read address) |
| out_offs_idx | output | IW | Offset element index (also register read address) |
| out_dst_idx | output | IW | Destination element index |
| out_ea | output | AW | Effective address |
| out_wb | output | 1 | Write-back request for this element |

## Verification
The hardest cases to reach are walks where the three counters drift apart. One example is a base counter that skips a run of clear source bits while the destination counter moves through a differently shaped mask. Another is a walk that ends because only one counter has run past VL, which happens when mask bits set beyond VL are the only ones left. Random masks with independent vector flags and VL values, combined with random back-pressure on `out_ready`, produce these drifts. Directed cases pin down a VL of zero, masks whose only set bits lie above VL, and a start pulse issued in the middle of a walk.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;
  typedef enum int {
    LANE_BASE = 0,
    LANE_OFFS = 1,
    LANE_DST  = 2
  } lane_e;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/idx_seq_lane.sv
module idx_seq_lane #(
  parameter int VL_MAX = 8,
  parameter int IW     = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              vec,
  input  logic [VL_MAX-1:0] mask,
  output logic [IW-1:0]     eff
);
  logic [IW-1:0] cnt_q;

  // lowest set mask position at or above 'from'; VL_MAX when none
  function automatic logic [IW-1:0] first_set_from(input logic [VL_MAX-1:0] m,
                                                   input logic [IW-1:0] from);
    logic [IW-1:0] r;
    r = IW'(VL_MAX);
    for (int p = VL_MAX - 1; p >= 0; p--) begin
      if (m[p] && (IW'(p) >= from)) r = IW'(p);
    end
    return r;
  endfunction

  assign eff = vec ? first_set_from(mask, cnt_q) : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (advance)  cnt_q <= eff + 1'b1;
  end
endmodule

// File: rtl/idx_seq_ea.sv
module idx_seq_ea #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offs,
  input  logic          valid,
  input  logic          upd,
  output logic [AW-1:0] ea,
  output logic          wb
);
  function automatic logic [AW-1:0] ea_sum(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a + b;
  endfunction

  assign ea = ea_sum(base, offs);
  assign wb = valid & upd;
endmodule

// File: rtl/idx_addr_seq.sv
module idx_addr_seq #(
  parameter int VL_MAX = 8,
  parameter int AW     = 32,
  parameter int IW     = $clog2(VL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     vl,
  input  logic [VL_MAX-1:0] src_pred,
  input  logic [VL_MAX-1:0] dst_pred,
  input  logic              base_vec,
  input  logic              offs_vec,
  input  logic              dst_vec,
  input  logic              upd_en,
  output logic              busy,
  output logic              done,
  input  logic [AW-1:0]     base_data,
  input  logic [AW-1:0]     offs_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IW-1:0]     out_base_idx,
  output logic [IW-1:0]     out_offs_idx,
  output logic [IW-1:0]     out_dst_idx,
  output logic [AW-1:0]     out_ea,
  output logic              out_wb
);
  import idx_seq_pkg::*;

  logic [IW-1:0]          vl_q;
  logic [VL_MAX-1:0]      sp_q, dp_q;
  logic [NUM_LANES-1:0]   vec_q;
  logic                   upd_q, busy_q, done_q;

  logic [IW-1:0]          eff [NUM_LANES];
  logic [NUM_LANES-1:0]   lane_ok;

  // named events for the checker
  logic accept, in_range, exhaust, fire, last_elem, finish;

  assign accept    = start & ~busy_q;
  assign in_range  = &lane_ok;
  assign exhaust   = busy_q & ~in_range;
  assign fire      = out_valid & out_ready;
  assign last_elem = ~vec_q[LANE_DST] | (~vec_q[LANE_BASE] & ~vec_q[LANE_OFFS]);
  assign finish    = exhaust | (fire & last_elem);

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [VL_MAX-1:0] lane_mask;
      if (l == int'(LANE_DST)) begin : g_dmask
        assign lane_mask = dp_q;
      end else begin : g_smask
        assign lane_mask = sp_q;
      end
      idx_seq_lane #(.VL_MAX(VL_MAX), .IW(IW)) u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (fire & vec_q[l]),
        .vec     (vec_q[l]),
        .mask    (lane_mask),
        .eff     (eff[l])
      );
      assign lane_ok[l] = eff[l] < vl_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q   <= '0;
      sp_q   <= '0;
      dp_q   <= '0;
      vec_q  <= '0;
      upd_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        vl_q   <= vl;
        sp_q   <= src_pred;
        dp_q   <= dst_pred;
        vec_q  <= {dst_vec, offs_vec, base_vec};
        upd_q  <= upd_en;
        busy_q <= 1'b1;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign out_valid    = busy_q & in_range;
  assign out_base_idx = eff[LANE_BASE];
  assign out_offs_idx = eff[LANE_OFFS];
  assign out_dst_idx  = eff[LANE_DST];

  idx_seq_ea #(.AW(AW)) u_ea (
    .base  (base_data),
    .offs  (offs_data),
    .valid (out_valid),
    .upd   (upd_q),
    .ea    (out_ea),
    .wb    (out_wb)
  );
endmodule

// File: rtl/idx_addr_seq_chk.sv
module idx_addr_seq_chk #(
  parameter int VL_MAX = 8,
  parameter int IW     = $clog2(VL_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy_q,
  input logic              done_q,
  input logic              out_valid,
  input logic              out_ready,
  input logic [IW-1:0]     out_base_idx,
  input logic [IW-1:0]     out_offs_idx,
  input logic [IW-1:0]     out_dst_idx,
  input logic [IW-1:0]     vl_q,
  input logic [VL_MAX-1:0] sp_q,
  input logic [VL_MAX-1:0] dp_q,
  input logic [2:0]        vec_q
);
  logic [VL_MAX-1:0] base_sh, offs_sh, dst_sh;
  assign base_sh = sp_q >> out_base_idx;
  assign offs_sh = sp_q >> out_offs_idx;
  assign dst_sh  = dp_q >> out_dst_idx;

  assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_base_idx < vl_q) && (out_offs_idx < vl_q) && (out_dst_idx < vl_q));

  assert_base_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (vec_q[0] ? base_sh[0] : (out_base_idx == '0)));

  assert_offs_pred_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (vec_q[1] ? offs_sh[0] : (out_offs_idx == '0)));

  assert_dst_pred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (vec_q[2] ? dst_sh[0] : (out_dst_idx == '0)));

  assert_scalar_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !vec_q[2]) |=> !out_valid);

  assert_scalar_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !vec_q[0] && !vec_q[1]) |=> !out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_base_idx)
                                  && $stable(out_offs_idx) && $stable(out_dst_idx));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> $stable(vl_q) && $stable(sp_q) && $stable(dp_q) && $stable(vec_q));
endmodule

bind idx_addr_seq idx_addr_seq_chk #(.VL_MAX(VL_MAX), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy_q       (busy_q),
  .done_q       (done_q),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_base_idx (out_base_idx),
  .out_offs_idx (out_offs_idx),
  .out_dst_idx  (out_dst_idx),
  .vl_q         (vl_q),
  .sp_q         (sp_q),
  .dp_q         (dp_q),
  .vec_q        (vec_q)
);

// File: tb/idx_addr_seq_bench.sv
module idx_addr_seq_bench;
  localparam int VL_MAX = 8;
  localparam int AW     = 32;
  localparam int IW     = $clog2(VL_MAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] vl = '0;
  logic [VL_MAX-1:0] src_pred = '0, dst_pred = '0;
  logic base_vec = 1'b0, offs_vec = 1'b0, dst_vec = 1'b0, upd_en = 1'b0;
  logic busy, done, out_valid, out_wb;
  logic out_ready = 1'b0;
  logic [AW-1:0] base_data, offs_data, out_ea;
  logic [IW-1:0] out_base_idx, out_offs_idx, out_dst_idx;

  int n_checks = 0;
  int n_fail = 0;
  int exp_b [16];
  int exp_o [16];
  int exp_d [16];
  int exp_n;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [AW-1:0] base_val(input logic [IW-1:0] idx);
    return 32'h4000_0000 + 32'(idx) * 32'h0001_0203;
  endfunction
  function automatic logic [AW-1:0] offs_val(input logic [IW-1:0] idx);
    return 32'(idx) * 32'h10 + 32'h5;
  endfunction

  assign base_data = base_val(out_base_idx);
  assign offs_data = offs_val(out_offs_idx);

  idx_addr_seq #(.VL_MAX(VL_MAX), .AW(AW)) u_idx_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_pred(src_pred), .dst_pred(dst_pred),
    .base_vec(base_vec), .offs_vec(offs_vec), .dst_vec(dst_vec), .upd_en(upd_en),
    .busy(busy), .done(done), .base_data(base_data), .offs_data(offs_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_base_idx(out_base_idx), .out_offs_idx(out_offs_idx), .out_dst_idx(out_dst_idx),
    .out_ea(out_ea), .out_wb(out_wb)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // reference walk, written from the requirements
  task automatic build_exp(input int len, input logic [7:0] sp, input logic [7:0] dp,
                           input bit bv, input bit ov, input bit dv);
    int b, o, d;
    b = 0; o = 0; d = 0; exp_n = 0;
    for (int step = 0; step < 16; step++) begin
      if (bv) while (b < 8 && !sp[b]) b++;
      if (ov) while (o < 8 && !sp[o]) o++;
      if (dv) while (d < 8 && !dp[d]) d++;
      if (b >= len || o >= len || d >= len) break;
      exp_b[exp_n] = b; exp_o[exp_n] = o; exp_d[exp_n] = d;
      exp_n++;
      if (!dv || (!bv && !ov)) break;
      if (bv) b++;
      if (ov) o++;
      if (dv) d++;
    end
  endtask

  task automatic run_op(input int len, input logic [7:0] sp, input logic [7:0] dp,
                        input bit bv, input bit ov, input bit dv, input bit upd,
                        input int ready_pct, input bit poke);
    int got;
    bit seen_done;
    build_exp(len, sp, dp, bv, ov, dv);
    @(negedge clk);
    vl = IW'(len); src_pred = sp; dst_pred = dp;
    base_vec = bv; offs_vec = ov; dst_vec = dv; upd_en = upd;
    start = 1'b1;
    got = 0; seen_done = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && cyc == 2) begin
        start = 1'b1; vl = IW'(1); src_pred = 8'h80; dst_pred = 8'h80;
        base_vec = 1'b0; offs_vec = 1'b0; dst_vec = 1'b0; upd_en = ~upd;
      end
      out_ready = ($urandom_range(0, 99) < 32'(ready_pct));
      #1;
      if (done) begin
        seen_done = 1'b1;
        check(busy == 1'b0, "R10 busy low with done", busy, 0);
        break;
      end
      if (out_valid && out_ready) begin
        if (got < exp_n) begin
          check(out_base_idx == IW'(exp_b[got]), "R2/R7 base index", out_base_idx, exp_b[got]);
          check(out_offs_idx == IW'(exp_o[got]), "R2/R7 offset index", out_offs_idx, exp_o[got]);
          check(out_dst_idx == IW'(exp_d[got]), "R3 destination index", out_dst_idx, exp_d[got]);
          check(out_ea == base_val(IW'(exp_b[got])) + offs_val(IW'(exp_o[got])),
                "R1 effective address", out_ea,
                base_val(IW'(exp_b[got])) + offs_val(IW'(exp_o[got])));
          check(out_wb == upd, "R8 write-back request", out_wb, upd);
        end
        got++;
      end
    end
    out_ready = 1'b0;
    check(seen_done, "R10 done pulse seen", seen_done, 1);
    check(got == exp_n, (!dv) ? "R5 element count" : ((!bv && !ov) ? "R6 element count" : "R4 element count"),
          got, exp_n);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10 single done cycle", {done, busy}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && out_valid == 1'b0, "R10 reset state",
          {busy, done, out_valid}, 0);

    run_op(0, 8'hFF, 8'hFF, 1, 1, 1, 1, 100, 0);            // R4 VL zero
    run_op(8, 8'hFF, 8'hFF, 1, 1, 1, 1, 100, 0);            // full vector
    run_op(8, 8'hA5, 8'h3C, 1, 1, 1, 0, 50, 0);             // R2 R3 sparse masks
    run_op(8, 8'h12, 8'hFF, 1, 0, 1, 1, 70, 0);             // offset scalar
    run_op(6, 8'hFF, 8'hFF, 1, 1, 0, 1, 60, 0);             // R5 scalar destination
    run_op(6, 8'h00, 8'h28, 0, 0, 1, 0, 60, 0);             // R6 scalar sources
    run_op(4, 8'hF0, 8'hFF, 1, 1, 1, 1, 100, 0);            // R4 set bits only above VL
    run_op(5, 8'h0F, 8'hC1, 0, 1, 1, 0, 100, 0);            // R4 destination runs out
    run_op(8, 8'hFF, 8'hFF, 1, 1, 1, 0, 100, 1);            // R9 start while busy
    run_op(8, 8'hFF, 8'hFF, 1, 1, 1, 1, 20, 0);             // R11 heavy back-pressure

    for (int t = 0; t < 80; t++) begin
      run_op($urandom_range(0, 8), 8'($urandom), 8'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             $urandom_range(25, 100), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule